// File: doc/BRIEF.md
# Serial Link Byte Receiver with Host Read Port

This block takes byte packets arriving on a one-wire, bit-serial, handshaked link and hands each byte to a host processor through a four-address, byte-wide register port. A packet is recognised by its leading pair of 1 bits. The eight payload bits follow, least significant first, and a single 0 bit closes the packet. The byte then sits in a one-entry holding register, a data-present flag is set, and, if the host has enabled it, an interrupt line goes high.

Flow control is per byte. The block sends no acknowledge when a byte lands. It sends one only after the host has read the byte and released chip select. The acknowledge is a short packet, a 1 bit then a 0 bit, and it tells the remote sender it may transmit again. The serial output is shared with a second acknowledge source that sits beside the block (`auxAckReq`). An arbiter never starts one packet over another, so a receive acknowledge that falls due while another packet is on the wire waits for that packet to finish.

One link bit lasts `BIT_CLKS` system clocks, 10 by default. Host strobes are synchronous to the system clock. An access begins on the clock where chip select is first seen low.

Top module: `linkRxAdaptor`

## Requirements
- R1: After reset, `inputInt` and `linkOut` are 0, and a read at select 2 returns 8'h00.
- R2: A packet 1,1,d0..d7,0 on `linkIn` makes select 0 read back the byte d7..d0, and makes bit 0 of the select-2 status read 1.
- R3: When the interrupt enable (bit 1, written at select 3) is 1, `inputInt` goes high at least 8 and at most 14 bit-times after the first bit of a data packet arrives. When the enable is 0, `inputInt` stays low and the status bit still sets.
- R4: The clock that first sees chip select low for a read at select 0 clears data-present, and `inputInt` is 0 from the next clock on.
- R5: After a select-0 read of a present byte, `linkOut` sends 1 for one bit-time and then 0 for one bit-time. The 1 starts no sooner than 0.8 and no later than 2.5 bit-times after chip select rises.
- R6: No acknowledge is sent after a status read, after a write, or after a select-0 read made while no byte is present.
- R7: An acknowledge that falls due while another packet is on `linkOut` starts only after that packet's 0 bit, and no later than 13.5 bit-times after chip select rises.
- R8: A write at select 0 leaves the held byte, the status bit and `inputInt` unchanged.
- R9: A status bit that reads 1 again after an earlier read had cleared it means a new byte has arrived.
- R10: A packet on `linkIn` whose second bit is 0 (an acknowledge packet) loads no byte and raises no interrupt.
- R11: Select 1 reads 8'h00. Select 3 reads the enable in bit 1 and data-present in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkIn | input | 1 | Serial receive line, synchronised inside |
| linkOut | output | 1 | Serial output carrying acknowledge packets |
| auxAckReq | input | 1 | One-clock request from a neighbouring source to send an acknowledge packet |
| csN | input | 1 | Active-low chip select |
| rnw | input | 1 | 1 for a read, 0 for a write |
| rs | input | 2 | Register select |
| dIn | input | 8 | Host write data |
| dOut | output | 8 | Host read data for the selected register |
| inputInt | output | 1 | Byte-ready interrupt |

## Verification
The bench builds the block with `BIT_CLKS` at 10. A whole data packet then takes 110 clocks, and the mid-bit sample lands five clocks into each bit, so the bounds of 0.8, 2.5 and 14 bit-times become whole clock counts the bench can test exactly. The neighbouring acknowledge lasts 20 clocks, which is longer than the 11-clock delay before a receive acknowledge. A request pulsed just before chip select is released therefore puts the collision of R7 within reach on every run.

// File: rtl/linkRxPkg.sv
package linkRxPkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] RS_DATA = 2'd0;
  localparam logic [1:0] RS_STAT = 2'd2;
  localparam logic [1:0] RS_CTRL = 2'd3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_FLAG,
    RX_DATA,
    RX_STOP
  } rxState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadBuf;
    logic clrPresent;
    logic wrIntEn;
    logic intEnVal;
  } dpStrobe_t;

endpackage

// File: rtl/linkRxData.sv
module linkRxData
  import linkRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        rs,
  output logic [BYTE_W-1:0] dOut,
  output logic              present,
  output logic              inputInt
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] dataReg;
  logic              intEn;
  logic [BYTE_W-1:0] nextByte;

  // first received bit ends up in bit 0
  assign nextByte = {strobe.shiftBit, shiftReg[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataReg  <= '0;
    end else begin
      if (strobe.shiftEn) shiftReg <= nextByte;
      if (strobe.loadBuf) dataReg  <= nextByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      present <= 1'b0;
    end else if (strobe.loadBuf) begin
      present <= 1'b1;
    end else if (strobe.clrPresent) begin
      present <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn <= 1'b0;
    end else if (strobe.wrIntEn) begin
      intEn <= strobe.intEnVal;
    end
  end

  assign inputInt = present & intEn;

  always_comb begin
    case (rs)
      RS_DATA: dOut = dataReg;
      RS_STAT: dOut = {{(BYTE_W-1){1'b0}}, present};
      RS_CTRL: dOut = {{(BYTE_W-2){1'b0}}, intEn, present};
      default: dOut = '0;
    endcase
  end

endmodule

// File: rtl/linkRxCtrl.sv
module linkRxCtrl
  import linkRxPkg::*;
#(
  parameter int BIT_CLKS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkIn,
  input  logic       auxAckReq,
  input  logic       csN,
  input  logic       rnw,
  input  logic [1:0] rs,
  input  logic       enBit,
  input  logic       present,
  output dpStrobe_t  strobe,
  output logic       linkOut
);

  localparam int CNT_W = $clog2(BIT_CLKS + 1);
  localparam int HALF  = BIT_CLKS / 2;
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_BIT  = CNT_W'(BIT_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  // ---------------- receive side ----------------
  logic sync1, lineNow, linePrev, lineRise;
  rxState_t rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [IDX_W-1:0] bitIdx;
  logic sampleNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1    <= 1'b0;
      lineNow  <= 1'b0;
      linePrev <= 1'b0;
    end else begin
      sync1    <= linkIn;
      lineNow  <= sync1;
      linePrev <= lineNow;
    end
  end

  assign lineRise  = lineNow & ~linePrev;
  assign sampleNow = (rxState == RX_DATA) && (rxCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      bitIdx  <= '0;
    end else if (rxState == RX_IDLE) begin
      if (lineRise) begin
        rxState <= RX_START;
        rxCnt   <= CNT_HALF;
      end
    end else if (rxCnt != '0) begin
      rxCnt <= rxCnt - 1'b1;
    end else begin
      rxCnt <= CNT_BIT;
      case (rxState)
        RX_START: rxState <= lineNow ? RX_FLAG : RX_IDLE;
        RX_FLAG: begin
          rxState <= lineNow ? RX_DATA : RX_IDLE;
          bitIdx  <= '0;
        end
        RX_DATA: begin
          bitIdx <= bitIdx + 1'b1;
          if (bitIdx == LAST_IDX) rxState <= RX_STOP;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // ---------------- host access ----------------
  logic csPrev, csFall, csRise, dataRead;
  logic readSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrev <= 1'b1;
    else       csPrev <= csN;
  end

  assign csFall   = csPrev & ~csN;
  assign csRise   = ~csPrev & csN;
  assign dataRead = csFall & rnw & (rs == RS_DATA);

  always_comb begin
    strobe            = '0;
    strobe.shiftBit   = lineNow;
    strobe.shiftEn    = sampleNow && (bitIdx != LAST_IDX);
    strobe.loadBuf    = sampleNow && (bitIdx == LAST_IDX);
    strobe.clrPresent = dataRead;
    strobe.wrIntEn    = csFall & ~rnw & (rs == RS_CTRL);
    strobe.intEnVal   = enBit;
  end

  // ---------------- acknowledge timing ----------------
  logic dlyRun, ackPend, auxPend;
  logic [CNT_W-1:0] dlyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readSeen <= 1'b0;
    end else if (csRise) begin
      readSeen <= 1'b0;
    end else if (dataRead && present) begin
      readSeen <= 1'b1;
    end
  end

  // ---------------- output arbiter and sender ----------------
  logic txBusy, txPhase, txLine;
  logic [CNT_W-1:0] txCnt;
  logic launchRx, launchAux;

  assign launchRx  = ~txBusy & ackPend;
  assign launchAux = ~txBusy & ~ackPend & auxPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyRun  <= 1'b0;
      dlyCnt  <= '0;
      ackPend <= 1'b0;
    end else begin
      if (launchRx) ackPend <= 1'b0;
      if (csRise && readSeen) begin
        dlyRun <= 1'b1;
        dlyCnt <= CNT_BIT;
      end else if (dlyRun) begin
        if (dlyCnt == '0) begin
          dlyRun  <= 1'b0;
          ackPend <= 1'b1;
        end else begin
          dlyCnt <= dlyCnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxPend <= 1'b0;
    end else if (auxAckReq) begin
      auxPend <= 1'b1;
    end else if (launchAux) begin
      auxPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txPhase <= 1'b0;
      txLine  <= 1'b0;
      txCnt   <= '0;
    end else if (!txBusy) begin
      if (launchRx || launchAux) begin
        txBusy  <= 1'b1;
        txPhase <= 1'b0;
        txLine  <= 1'b1;
        txCnt   <= CNT_BIT;
      end
    end else if (txCnt != '0) begin
      txCnt <= txCnt - 1'b1;
    end else if (!txPhase) begin
      txPhase <= 1'b1;
      txLine  <= 1'b0;
      txCnt   <= CNT_BIT;
    end else begin
      txBusy <= 1'b0;
    end
  end

  assign linkOut = txLine;

endmodule

// File: rtl/linkRxAdaptor.sv
module linkRxAdaptor
  import linkRxPkg::*;
#(
  parameter int BIT_CLKS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkIn,
  output logic              linkOut,
  input  logic              auxAckReq,
  input  logic              csN,
  input  logic              rnw,
  input  logic [1:0]        rs,
  input  logic [BYTE_W-1:0] dIn,
  output logic [BYTE_W-1:0] dOut,
  output logic              inputInt
);

  dpStrobe_t strobe;
  logic      present;
  logic      dInUnused;

  assign dInUnused = ^{dIn[BYTE_W-1:2], dIn[0]};

  linkRxCtrl #(.BIT_CLKS(BIT_CLKS)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .linkIn    (linkIn),
    .auxAckReq (auxAckReq),
    .csN       (csN),
    .rnw       (rnw),
    .rs        (rs),
    .enBit     (dIn[1]),
    .present   (present),
    .strobe    (strobe),
    .linkOut   (linkOut)
  );

  linkRxData i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rs       (rs),
    .dOut     (dOut),
    .present  (present),
    .inputInt (inputInt)
  );

endmodule

// File: rtl/linkRxChecker.sv
module linkRxChecker #(
  parameter int BIT_CLKS = 10
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       rnw,
  input logic [1:0] rs,
  input logic       inputInt,
  input logic       linkOut
);

  logic        csPrevC;
  logic        hadHigh;
  logic [15:0] hiRun;
  logic [15:0] loRun;
  logic        rdFall, wrFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrevC <= 1'b1;
      hadHigh <= 1'b0;
      hiRun   <= '0;
      loRun   <= '0;
    end else begin
      csPrevC <= csN;
      if (linkOut) begin
        hadHigh <= 1'b1;
        loRun   <= '0;
        if (hiRun != 16'hFFFF) hiRun <= hiRun + 1'b1;
      end else begin
        hiRun <= '0;
        if (loRun != 16'hFFFF) loRun <= loRun + 1'b1;
      end
    end
  end

  assign rdFall = csPrevC & ~csN & rnw & (rs == 2'd0);
  assign wrFall = csPrevC & ~csN & ~rnw & (rs == 2'd0);

  AST_INT_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdFall |=> !inputInt); // R4

  AST_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrFall && inputInt) |=> inputInt); // R8

  AST_ACK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkOut) |-> (hiRun == 16'(BIT_CLKS))); // R5

  AST_ACK_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(linkOut) && hadHigh) |-> (loRun >= 16'(BIT_CLKS))); // R7

endmodule

bind linkRxAdaptor linkRxChecker #(.BIT_CLKS(BIT_CLKS)) i_chk (.*);

// File: tb/test_linkRxAdaptor.sv
module test_linkRxAdaptor;

  localparam int CLK_PERIOD = 10;
  localparam int BIT        = 10;
  localparam int NVEC       = 5;
  localparam logic [7:0] VEC_BYTE [NVEC] = '{8'hA5, 8'h01, 8'h80, 8'h3C, 8'hFF};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       linkIn = 1'b0;
  logic       linkOut;
  logic       auxAckReq = 1'b0;
  logic       csN = 1'b1;
  logic       rnw = 1'b1;
  logic [1:0] rs = 2'd0;
  logic [7:0] dIn = 8'h00;
  logic [7:0] dOut;
  logic       inputInt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  linkRxAdaptor #(.BIT_CLKS(BIT)) i_linkRxAdaptor (
    .clk(clk), .rstN(rstN), .linkIn(linkIn), .linkOut(linkOut),
    .auxAckReq(auxAckReq), .csN(csN), .rnw(rnw), .rs(rs),
    .dIn(dIn), .dOut(dOut), .inputInt(inputInt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic sendBit(input logic v);
    linkIn = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendBit(1'b1);
    sendBit(1'b1);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
    sendBit(1'b0);
  endtask

  task automatic sendTimed(input logic [7:0] b, output int intAt);
    int at = -1;
    fork
      sendByte(b);
      for (int n = 1; n <= 16*BIT; n++) begin
        @(negedge clk);
        if (inputInt && at < 0) at = n;
      end
    join
    intAt = at;
  endtask

  task automatic hostRead(input logic [1:0] sel, input bit pulseAux,
                          output logic [7:0] data, output logic intMid);
    rs = sel; rnw = 1'b1; csN = 1'b0;
    repeat (3) @(negedge clk);
    data = dOut;
    intMid = inputInt;
    if (pulseAux) auxAckReq = 1'b1;
    @(negedge clk);
    auxAckReq = 1'b0;
    repeat (2) @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] d);
    rs = sel; rnw = 1'b0; dIn = d; csN = 1'b0;
    repeat (6) @(negedge clk);
    csN = 1'b1;
    rnw = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitAck(output int dly);
    int n = 0;
    while (!linkOut && n < 60) begin
      @(negedge clk);
      n++;
    end
    dly = n;
  endtask

  task automatic checkShape(input string req);
    repeat (BIT/2) @(negedge clk);
    check(linkOut == 1'b1, req, linkOut, 1);
    repeat (BIT) @(negedge clk);
    check(linkOut == 1'b0, req, linkOut, 0);
    repeat (BIT) @(negedge clk);
  endtask

  task automatic noAck(input int cycles, input string req);
    int seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (linkOut) seen = 1;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    logic [7:0] d;
    logic im;
    int intAt, dly, n, lo;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(inputInt == 1'b0, "R1 inputInt", inputInt, 0);
    check(linkOut == 1'b0, "R1 linkOut", linkOut, 0);
    hostRead(2'd2, 1'b0, d, im); @(negedge clk);
    check(d == 8'h00, "R1 status", d, 0);
    // R11: select 1 reads zero
    hostRead(2'd1, 1'b0, d, im); @(negedge clk);
    check(d == 8'h00, "R11 sel1", d, 0);
    // R6: data read with nothing present sends no ack
    hostRead(2'd0, 1'b0, d, im);
    noAck(4*BIT, "R6 empty read");
    // R11: enable write and read back
    hostWrite(2'd3, 8'h02);
    hostRead(2'd3, 1'b0, d, im); @(negedge clk);
    check(d == 8'h02, "R11 ctrl", d, 2);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      sendTimed(VEC_BYTE[v], intAt);
      check(intAt >= 8*BIT && intAt <= 14*BIT, "R3 int time", intAt, 14*BIT);
      hostRead(2'd2, 1'b0, d, im); @(negedge clk);
      check(d == 8'h01, "R2 status", d, 1);
      hostRead(2'd0, 1'b0, d, im);
      check(d == VEC_BYTE[v], "R2 byte", d, VEC_BYTE[v]);
      check(im == 1'b0, "R4 int cleared", im, 0);
      waitAck(dly);
      check(dly >= 8 && dly <= 25, "R5 ack start", dly, BIT+2);
      checkShape("R5 ack shape");
    end

    // R9: status comes back after a new byte
    hostRead(2'd2, 1'b0, d, im); @(negedge clk);
    check(d == 8'h00, "R9 status empty", d, 0);
    sendTimed(8'h5A, intAt);
    hostRead(2'd2, 1'b0, d, im); @(negedge clk);
    check(d == 8'h01, "R9 status new", d, 1);
    // R8: write to data register ignored
    hostWrite(2'd0, 8'hC3);
    check(inputInt == 1'b1, "R8 int kept", inputInt, 1);
    hostRead(2'd2, 1'b0, d, im); @(negedge clk);
    check(d == 8'h01, "R8 status kept", d, 1);
    noAck(2*BIT, "R6 write and status");
    hostRead(2'd0, 1'b0, d, im);
    check(d == 8'h5A, "R8 byte kept", d, 8'h5A);
    waitAck(dly);
    check(dly >= 8 && dly <= 25, "R5 ack start", dly, BIT+2);
    checkShape("R5 ack shape");

    // R3: interrupt disabled
    hostWrite(2'd3, 8'h00);
    sendTimed(8'h96, intAt);
    check(intAt == -1, "R3 disabled", intAt, -1);
    hostRead(2'd2, 1'b0, d, im); @(negedge clk);
    check(d == 8'h01, "R3 status set", d, 1);
    hostRead(2'd0, 1'b0, d, im);
    check(d == 8'h96, "R2 byte", d, 8'h96);
    waitAck(dly);
    checkShape("R5 ack shape");
    hostWrite(2'd3, 8'h02);

    // R10: incoming acknowledge packet ignored
    sendBit(1'b1);
    sendBit(1'b0);
    repeat (12*BIT) @(negedge clk);
    check(inputInt == 1'b0, "R10 no int", inputInt, 0);
    hostRead(2'd2, 1'b0, d, im); @(negedge clk);
    check(d == 8'h00, "R10 no byte", d, 0);

    // R6: status read with byte present sends no ack
    sendTimed(8'h11, intAt);
    hostRead(2'd2, 1'b0, d, im);
    noAck(4*BIT, "R6 status read");
    hostRead(2'd0, 1'b0, d, im);
    waitAck(dly);
    checkShape("R5 ack shape");

    // R7: collision with an acknowledge already on the line
    sendTimed(8'h77, intAt);
    hostRead(2'd0, 1'b1, d, im);
    check(d == 8'h77, "R2 byte", d, 8'h77);
    check(linkOut == 1'b1, "R7 other packet in flight", linkOut, 1);
    n = 0;
    while (linkOut && n < 200) begin @(negedge clk); n++; end
    lo = 0;
    while (!linkOut && n < 200) begin @(negedge clk); n++; lo++; end
    check(n > BIT+2 && n <= (27*BIT)/2, "R7 delayed start", n, 2*BIT);
    check(lo >= BIT, "R7 no overlap", lo, BIT);
    checkShape("R7 ack shape");

    report();
  end

endmodule